// File: doc/BRIEF.md
# Queued Conversion Sequencer

This block runs a list of analog conversion commands held in a 64-entry table. Software fills the table over a simple word-addressed register bus. Each 16-bit command names an input channel, a code for the length of the initial sample phase, an option to skip that phase, and a request to stop after the command. Writing the start bit makes the sequencer read the entries in index order. For each entry it drives the channel select and the sample-phase strobes, then hands the conversion to an external converter core through a request/done handshake.

Each returned result goes into a result table at the same index as its command. The queue ends at the first entry whose channel field holds the reserved value 63, or after entry 63 if no such entry exists. A command that asks to stop raises a pause flag. The next start then resumes at the following entry. The completion and pause flags drive an interrupt line when it is enabled. A start that arrives while the queue is running raises an overrun flag and is otherwise ignored.

Bus map (word index on `bus_addr`): 0x00–0x3F command table, 0x40–0x7F result table (read only, result in bits [RES_W-1:0], upper bits zero), 0x80 control, 0x81 status.

Top module: `qseq_top`

## Requirements
- R1: A command word carries the channel in bits [5:0], the initial-sample code in bits [7:6], the bypass flag in bit 8 and the pause flag in bit 9; bits [15:10] are ignored. `conv_chan` shows the channel of the executing command while any phase output is high.
- R2: Writing 1 to control bit 0 while the sequencer is idle starts execution at entry 0. Entries then execute strictly in ascending index order, and each command takes one fetch cycle before its phases.
- R3: A command runs an initial sample phase of 2, 4, 8 or 16 cycles for codes 0–3 (`smp_init` high), unless bypass is set, in which case this phase is skipped. It then runs a final sample phase of FINAL_LEN cycles (`smp_final` high). It then holds `conv_req` high until the cycle in which `conv_done` is high. At most one of these three outputs is high at a time.
- R4: The `conv_result` value taken with `conv_done` for command entry k is stored in result entry k (bus index 0x40+k).
- R5: Fetching an entry whose channel is 63 ends the queue and sets the completion flag (status bit 0). When entry 0 holds 63, the queue ends with no conversion and no result entry changes.
- R6: When entry 63 completes without an end marker having been reached, execution stops, the completion flag is set and the pointer stays at 63.
- R7: When a command with the pause flag completes, the pause flag (status bit 1) is set. The sequencer then stays idle with all phase outputs low, and the pointer shows the next entry. The next start resumes at that entry.
- R8: `irq` is high exactly when control bit 1 (interrupt enable) is 1 and the completion or pause flag is set.
- R9: Status bits [13:8] show the index of the entry being executed. Status bit 15 is 1 while a queue is being executed and 0 when idle or paused.
- R10: A start while bit 15 is 1 sets the overrun flag (status bit 2) and does not change the running execution.
- R11: Writing the status word clears each of bits [2:0] where the written bit is 1 and leaves the others unchanged.
- R12: After reset all flags, the pointer, interrupt enable and all phase outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the converter timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Word index for read and write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| smp_init | output | 1 | Initial sample phase active |
| smp_final | output | 1 | Final sample phase active |
| conv_req | output | 1 | Conversion requested from the converter core |
| conv_chan | output | 6 | Channel select of the executing command |
| conv_done | input | 1 | Converter core returns a result this cycle |
| conv_result | input | RES_W | Converter result, taken with `conv_done` |
| irq | output | 1 | Interrupt request |

## Verification
The hardest states to reach are the pause-then-resume path and the run that falls off the end of a full table without a marker. The first needs a stop-flagged command, a quiet interval with the flags cleared and a second start. The second needs all 64 entries written with non-marker channels. The bench scripts both. It keeps the status register selected on the bus during every run, so the pointer is compared on each cycle against a timeline built from the command list. A start is also injected in the middle of a run to show that the timeline is undisturbed and that only the overrun flag changes.

// File: rtl/qseq_pkg.sv
package qseq_pkg;
  localparam int DEPTH  = 64;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int WORD_W = 16;
  localparam int ADDR_W = 8;
  localparam int CHAN_W = 6;

  localparam logic [CHAN_W-1:0] EOQ_CHAN  = 6'd63;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h80;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 8'h81;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_INIT, S_FINAL, S_CONV, S_PAUSE
  } seq_state_t;

  // Lower ten bits of a command word, MSB first
  typedef struct packed {
    logic              pause;
    logic              bypass;
    logic [1:0]        ist;
    logic [CHAN_W-1:0] chan;
  } cmd_fields_t;

  function automatic logic [4:0] init_len(input logic [1:0] code);
    return 5'd2 << code;
  endfunction
endpackage

// File: rtl/qseq_tables.sv
module qseq_tables
  import qseq_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic              clk,
  input  logic              cmd_we,
  input  logic [IDX_W-1:0]  cmd_widx,
  input  logic [WORD_W-1:0] cmd_wdata,
  input  logic [IDX_W-1:0]  fetch_idx,
  output cmd_fields_t       fetch_cmd,
  input  logic              res_we,
  input  logic [IDX_W-1:0]  res_widx,
  input  logic [RES_W-1:0]  res_wdata,
  input  logic              rd_res_sel,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data
);
  localparam int PAD_W = WORD_W - RES_W;

  logic [WORD_W-1:0] cmd_mem [DEPTH];
  logic [RES_W-1:0]  res_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (cmd_we) cmd_mem[cmd_widx] <= cmd_wdata;
  end

  always_ff @(posedge clk) begin
    if (res_we) res_mem[res_widx] <= res_wdata;
  end

  assign fetch_cmd = cmd_fields_t'(cmd_mem[fetch_idx][9:0]);

  always_comb begin
    if (rd_res_sel) rd_data = {{PAD_W{1'b0}}, res_mem[rd_idx]};
    else            rd_data = cmd_mem[rd_idx];
  end
endmodule

// File: rtl/qseq_ctrl.sv
module qseq_ctrl
  import qseq_pkg::*;
#(
  parameter int FINAL_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        flag_clr,
  input  cmd_fields_t       fetch_cmd,
  input  logic              conv_done,
  output logic [IDX_W-1:0]  ptr,
  output logic              busy,
  output logic              smp_init,
  output logic              smp_final,
  output logic              conv_req,
  output logic [CHAN_W-1:0] conv_chan,
  output logic              res_we,
  output logic              cf,
  output logic              pf,
  output logic              tor
);
  localparam int CNT_W = $clog2(FINAL_LEN > 16 ? FINAL_LEN : 16) + 1;
  localparam logic [CNT_W-1:0] FIN_LOAD = CNT_W'(FINAL_LEN - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  seq_state_t        st, st_n;
  logic [IDX_W-1:0]  ptr_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [CHAN_W-1:0] chan_q, chan_n;
  logic              pause_q, pause_n;
  logic              cf_set, pf_set, tor_set;

  assign busy = (st == S_FETCH) || (st == S_INIT) || (st == S_FINAL) || (st == S_CONV);

  always_comb begin
    st_n    = st;
    ptr_n   = ptr;
    cnt_n   = cnt;
    chan_n  = chan_q;
    pause_n = pause_q;
    cf_set  = 1'b0;
    pf_set  = 1'b0;
    res_we  = 1'b0;
    case (st)
      S_IDLE: if (start) begin
        st_n  = S_FETCH;
        ptr_n = '0;
      end
      S_PAUSE: if (start) st_n = S_FETCH;
      S_FETCH: begin
        chan_n  = fetch_cmd.chan;
        pause_n = fetch_cmd.pause;
        if (fetch_cmd.chan == EOQ_CHAN) begin
          st_n   = S_IDLE;
          cf_set = 1'b1;
        end else if (fetch_cmd.bypass) begin
          st_n  = S_FINAL;
          cnt_n = FIN_LOAD;
        end else begin
          st_n  = S_INIT;
          cnt_n = CNT_W'(init_len(fetch_cmd.ist)) - CNT_W'(1);
        end
      end
      S_INIT: if (cnt == '0) begin
        st_n  = S_FINAL;
        cnt_n = FIN_LOAD;
      end else cnt_n = cnt - CNT_W'(1);
      S_FINAL: if (cnt == '0) st_n = S_CONV;
               else cnt_n = cnt - CNT_W'(1);
      S_CONV: if (conv_done) begin
        res_we = 1'b1;
        if (ptr == LAST_IDX) begin
          st_n   = S_IDLE;
          cf_set = 1'b1;
          pf_set = pause_q;
        end else begin
          ptr_n = ptr + IDX_W'(1);
          if (pause_q) begin
            st_n   = S_PAUSE;
            pf_set = 1'b1;
          end else st_n = S_FETCH;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  assign tor_set = start && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ptr     <= '0;
      cnt     <= '0;
      chan_q  <= '0;
      pause_q <= 1'b0;
      cf      <= 1'b0;
      pf      <= 1'b0;
      tor     <= 1'b0;
    end else begin
      st      <= st_n;
      ptr     <= ptr_n;
      cnt     <= cnt_n;
      chan_q  <= chan_n;
      pause_q <= pause_n;
      cf      <= cf_set  | (cf  & ~flag_clr[0]);
      pf      <= pf_set  | (pf  & ~flag_clr[1]);
      tor     <= tor_set | (tor & ~flag_clr[2]);
    end
  end

  assign smp_init  = (st == S_INIT);
  assign smp_final = (st == S_FINAL);
  assign conv_req  = (st == S_CONV);
  assign conv_chan = chan_q;

  // R3
  init_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_INIT && cnt != '0) |=> (st == S_INIT));
  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH || st == S_INIT || st == S_FINAL) |=> $stable(ptr));
  // R5
  cf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cf) |-> ($past(st) == S_FETCH || $past(st) == S_CONV));
  // R10
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> tor);
  // R7
  pause_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PAUSE && !start) |=> (st == S_PAUSE && $stable(ptr)));
endmodule

// File: rtl/qseq_top.sv
module qseq_top
  import qseq_pkg::*;
#(
  parameter int FINAL_LEN = 4,
  parameter int RES_W     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [7:0]        bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              smp_init,
  output logic              smp_final,
  output logic              conv_req,
  output logic [5:0]        conv_chan,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  output logic              irq
);
  logic              ctrl_wr, stat_wr, start, ie_q, ie_n;
  logic [2:0]        flag_clr;
  logic              cmd_we, res_we, busy, cf, pf, tor;
  logic [IDX_W-1:0]  ptr;
  cmd_fields_t       fetch_cmd;
  logic [WORD_W-1:0] tab_rdata;

  assign ctrl_wr  = bus_we && (bus_addr == CTRL_ADDR);
  assign stat_wr  = bus_we && (bus_addr == STAT_ADDR);
  assign start    = ctrl_wr && bus_wdata[0];
  assign flag_clr = stat_wr ? bus_wdata[2:0] : 3'b000;
  assign cmd_we   = bus_we && (bus_addr[7:6] == 2'b00);
  assign ie_n     = ctrl_wr ? bus_wdata[1] : ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ie_q <= 1'b0;
    else        ie_q <= ie_n;
  end

  qseq_tables #(.RES_W(RES_W)) u_tables (
    .clk        (clk),
    .cmd_we     (cmd_we),
    .cmd_widx   (bus_addr[5:0]),
    .cmd_wdata  (bus_wdata),
    .fetch_idx  (ptr),
    .fetch_cmd  (fetch_cmd),
    .res_we     (res_we),
    .res_widx   (ptr),
    .res_wdata  (conv_result),
    .rd_res_sel (bus_addr[6]),
    .rd_idx     (bus_addr[5:0]),
    .rd_data    (tab_rdata)
  );

  qseq_ctrl #(.FINAL_LEN(FINAL_LEN)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .flag_clr  (flag_clr),
    .fetch_cmd (fetch_cmd),
    .conv_done (conv_done),
    .ptr       (ptr),
    .busy      (busy),
    .smp_init  (smp_init),
    .smp_final (smp_final),
    .conv_req  (conv_req),
    .conv_chan (conv_chan),
    .res_we    (res_we),
    .cf        (cf),
    .pf        (pf),
    .tor       (tor)
  );

  always_comb begin
    if (!bus_addr[7])              bus_rdata = tab_rdata;
    else if (bus_addr == CTRL_ADDR) bus_rdata = {14'b0, ie_q, 1'b0};
    else if (bus_addr == STAT_ADDR) bus_rdata = {busy, 1'b0, ptr, 5'b0, tor, pf, cf};
    else                            bus_rdata = '0;
  end

  assign irq = ie_q && (cf || pf);

  // R8
  irq_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q && $rose(cf)) |-> irq);
  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_q) |-> !irq);
endmodule

// File: tb/qseq_top_test.sv
module qseq_top_test;
  localparam int FIN = 4;
  localparam logic [7:0] A_CTRL = 8'h80;
  localparam logic [7:0] A_STAT = 8'h81;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        smp_init, smp_final, conv_req, irq;
  logic [5:0]  conv_chan;
  logic        conv_done = 1'b0;
  logic [9:0]  conv_result = 10'h0;

  int checks = 0;
  int fails = 0;
  int exp_q[$];
  int exp_res[64];
  int plan_n = 0;
  int nconv = 0;
  int kcnt = 0;
  logic ie_b = 1'b0;

  always #4 clk = ~clk;

  qseq_top #(.FINAL_LEN(FIN), .RES_W(10)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smp_init(smp_init),
    .smp_final(smp_final), .conv_req(conv_req), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_result(conv_result), .irq(irq)
  );

  function automatic int res_fn(int ch, int n);
    return (ch * 37 + n * 11 + 5) & 1023;
  endfunction

  // converter core model: three request cycles per conversion
  always @(negedge clk) begin
    if (conv_done) begin
      conv_done = 1'b0;
      kcnt = 0;
    end else if (conv_req) begin
      kcnt++;
      if (kcnt == 3) begin
        conv_done   = 1'b1;
        conv_result = 10'(res_fn(int'(conv_chan), nconv));
        nconv++;
      end
    end else kcnt = 0;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] mk(bit p, bit byp, int ist, int ch);
    return {6'b101010, p, byp, 2'(ist), 6'(ch)};
  endfunction

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // expected cycle-by-cycle timeline of one command
  task automatic plan_cmd(int idx, logic [15:0] w);
    int ch = int'(w[5:0]);
    exp_q.push_back(idx << 12);
    if (ch == 63) return;
    if (!w[8]) repeat (2 << w[7:6]) exp_q.push_back((idx << 12) | (ch << 4) | 4);
    repeat (FIN) exp_q.push_back((idx << 12) | (ch << 4) | 2);
    repeat (3) exp_q.push_back((idx << 12) | (ch << 4) | 1);
    exp_res[idx] = res_fn(ch, plan_n);
    plan_n++;
  endtask

  task automatic start_scan();
    @(negedge clk);
    bus_we = 1'b1; bus_addr = A_CTRL; bus_wdata = {14'b0, ie_b, 1'b1};
    @(posedge clk);
    #1 bus_we = 1'b0; bus_addr = A_STAT;
  endtask

  task automatic run_timeline(int tor_at);
    int n = 0;
    while (exp_q.size() > 0) begin
      int e;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = A_STAT;
      #1 e = exp_q.pop_front();
      check("R3 phase outputs", int'({smp_init, smp_final, conv_req}), e & 7);
      check("R2/R9 pointer order", int'(bus_rdata[13:8]), (e >> 12) & 63);
      check("R9 busy", int'(bus_rdata[15]), 1);
      if ((e & 7) != 0) check("R1 channel", int'(conv_chan), (e >> 4) & 63);
      if (n == tor_at) begin
        bus_we = 1'b1; bus_addr = A_CTRL; bus_wdata = {14'b0, ie_b, 1'b1};
      end
      n++;
    end
  endtask

  task automatic check_res(int idx, string req);
    logic [15:0] d;
    rd(8'(64 + idx), d);
    check(req, int'(d), exp_res[idx]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [15:0] keep0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    rd(A_STAT, d);
    check("R12 status after reset", int'(d), 0);
    rd(A_CTRL, d);
    check("R12 ctrl after reset", int'(d), 0);
    check("R12 outputs after reset", int'({smp_init, smp_final, conv_req, irq}), 0);

    // scan with mixed sample codes, bypass and marker
    ie_b = 1'b1;
    wr(A_CTRL, 16'h0002);
    wr(8'd0, mk(0, 0, 0, 5));
    wr(8'd1, mk(0, 0, 3, 12));
    wr(8'd2, mk(0, 1, 2, 33));
    wr(8'd3, mk(0, 0, 1, 63));
    rd(8'd1, d);
    check("R1 command readback", int'(d), int'(mk(0, 0, 3, 12)));
    plan_cmd(0, mk(0, 0, 0, 5));
    plan_cmd(1, mk(0, 0, 3, 12));
    plan_cmd(2, mk(0, 1, 2, 33));
    plan_cmd(3, mk(0, 0, 1, 63));
    start_scan();
    run_timeline(-1);
    rd(A_STAT, d);
    check("R5 end marker sets CF, idle", int'(d), (3 << 8) | 1);
    check("R8 irq with CF", int'(irq), 1);
    check_res(0, "R4 result slot 0");
    check_res(1, "R4 result slot 1");
    check_res(2, "R4 result slot 2");

    // R11 writing zeros keeps flags, writing one clears
    wr(A_STAT, 16'h0000);
    rd(A_STAT, d);
    check("R11 zero write keeps CF", int'(d[0]), 1);
    wr(A_STAT, 16'h0001);
    rd(A_STAT, d);
    check("R11 CF cleared", int'(d[2:0]), 0);
    check("R8 irq low after clear", int'(irq), 0);

    // R7 pause then resume
    wr(8'd0, mk(1, 1, 0, 7));
    wr(8'd1, mk(0, 0, 1, 8));
    wr(8'd2, mk(0, 0, 0, 63));
    plan_cmd(0, mk(1, 1, 0, 7));
    start_scan();
    run_timeline(-1);
    rd(A_STAT, d);
    check("R7 paused status", int'(d), (1 << 8) | 2);
    check("R8 irq with PF", int'(irq), 1);
    repeat (10) begin
      @(negedge clk); #1;
      check("R7 idle while paused", int'({smp_init, smp_final, conv_req}), 0);
    end
    rd(A_STAT, d);
    check("R7 pointer holds", int'(d), (1 << 8) | 2);
    wr(A_STAT, 16'h0002);
    plan_cmd(1, mk(0, 0, 1, 8));
    plan_cmd(2, mk(0, 0, 0, 63));
    start_scan();
    run_timeline(-1);
    rd(A_STAT, d);
    check("R7 resumed run ends with CF", int'(d), (2 << 8) | 1);
    check_res(0, "R4 paused command result");
    check_res(1, "R4 resumed command result");

    // R10 overrun while running, interrupt disabled
    wr(A_STAT, 16'h0007);
    ie_b = 1'b0;
    wr(A_CTRL, 16'h0000);
    wr(8'd0, mk(0, 1, 1, 20));
    wr(8'd1, mk(0, 0, 0, 63));
    plan_cmd(0, mk(0, 1, 1, 20));
    plan_cmd(1, mk(0, 0, 0, 63));
    start_scan();
    run_timeline(3);
    rd(A_STAT, d);
    check("R10 overrun flag, run intact", int'(d), (1 << 8) | 5);
    check("R8 irq masked", int'(irq), 0);
    check_res(0, "R4 result after overrun");

    // R5 empty queue
    wr(A_STAT, 16'h0007);
    rd(8'd64, keep0);
    wr(8'd0, mk(0, 0, 2, 63));
    plan_cmd(0, mk(0, 0, 2, 63));
    start_scan();
    run_timeline(-1);
    rd(A_STAT, d);
    check("R5 empty queue sets CF", int'(d), 1);
    rd(8'd64, d);
    check("R5 empty queue leaves result 0", int'(d), int'(keep0));

    // R6 full table without marker
    wr(A_STAT, 16'h0007);
    for (int i = 0; i < 64; i++) wr(8'(i), mk(0, 1, 0, i % 63));
    for (int i = 0; i < 64; i++) plan_cmd(i, mk(0, 1, 0, i % 63));
    start_scan();
    run_timeline(-1);
    rd(A_STAT, d);
    check("R6 stop after entry 63", int'(d), (63 << 8) | 1);
    repeat (5) begin
      @(negedge clk); #1;
      check("R6 idle after last entry", int'({smp_init, smp_final, conv_req}), 0);
    end
    check_res(0, "R6 first result");
    check_res(63, "R6 last result");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule